// File: doc/BRIEF.md
# Seven-to-one display link serializer

This block turns one pixel word per pixel clock into five serial streams. The word is built from three 8-bit colour channels, a line-sync bit, a frame-sync bit, a data-enable bit and a spare bit. It is cut into four 7-bit groups. Each group is shifted out on its own data lane, one bit per tick of a fast enable (`bit_en`) that runs at seven times the pixel rate. A fifth lane carries a framing pattern so that a receiver can find the word boundaries. The analog drivers and the frequency multiplier sit outside the block. The block runs on one system clock, and `bit_en` marks the fast bit slots.

The pixel clock arrives as a sampled input. It passes through a synchronizer, and the data word passes through a matching pipeline. An input pin chooses whether the word is taken on the rising or the falling pixel-clock edge. If no pixel-clock edge arrives for a fixed number of bit ticks, all five lanes are forced low. They restart cleanly at a word boundary once edges return. Taking the active-low power-down input low resets the logic and releases all serial outputs to high impedance at once. Clock, data and power-down may be applied in any order.

Top module: `pxl_link_serializer`

## Requirements
- R1: The word is packed as red in bits 7..0, green in bits 15..8, blue in bits 23..16, line sync in bit 24, frame sync in bit 25, data enable in bit 26 and spare in bit 27. Data lane k carries word bits 7k+6 down to 7k, most significant first, with bit 7k+6 in slot 0.
- R2: Each lane emits one bit per `bit_en` tick, and a new word starts every seven ticks. While `bit_en` is low, all five outputs hold their values.
- R3: The frame lane shows 1,1,0,0,0,1,1 over slots 0 to 6 of every word, so the first bit of each data group lines up with the first 1 of that run.
- R4: With `strobe_rise` high, the word present at the rising pixel-clock edge is sent. With `strobe_rise` low, the word present at the falling edge is sent. Words are sent in capture order, with none skipped or repeated.
- R5: Once 32 `bit_en` ticks pass with no pixel-clock edge, all five lanes are driven low and stay low while the clock stays absent. Before that limit the lanes keep running.
- R6: After pixel-clock edges return, output resumes at the next word boundary, and the following words are sent correctly again without a reset.
- R7: While `pd_n` is low, all five outputs are high impedance and the logic is held in reset. After `pd_n` rises, words that arrive later are sent correctly, even if the pixel clock was already running during power-down.
- R8: While `rst_n` is low and `pd_n` is high, all five lanes are driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down; resets the logic and floats the outputs |
| bit_en | input | 1 | Bit-slot enable, seven ticks per pixel clock |
| pix_clk | input | 1 | Pixel clock, sampled on `clk` |
| strobe_rise | input | 1 | 1: capture on the rising edge; 0: capture on the falling edge |
| red | input | 8 | Red channel |
| green | input | 8 | Green channel |
| blue | input | 8 | Blue channel |
| line_sync | input | 1 | Line sync control bit |
| frame_sync | input | 1 | Frame sync control bit |
| data_en | input | 1 | Data-enable control bit |
| spare | input | 1 | Spare bit carried in the word |
| lane_o | output | 4 | Serial data lanes |
| clk_lane_o | output | 1 | Serial framing lane |

## Verification
A pixel-clock edge is seen two `clk` cycles after it is driven, and the word is registered on the cycle after that. The word goes onto the lanes at the next boundary after slot 6, which is up to seven ticks later, with each bit one register stage behind its slot. That gap is not fixed, so the bench does not count cycles from the pixel edge. It samples every tick, finds each word boundary from the 1100011 run on the frame lane, rebuilds the word from the seven preceding samples of each lane, and checks that the rebuilt words follow the stimulus order. The loss checks look at the lanes well before and well after the 32-tick limit, which leaves room for the synchronizer stages. The power-down check reads the outputs in the same cycle that `pd_n` falls, because the float is combinational.

// File: rtl/pxl_pkg.sv
`timescale 1ns/1ps
package pxl_pkg;
  localparam int unsigned COLOR_W    = 8;
  localparam int unsigned SLOTS      = 7;
  localparam int unsigned LOSS_TICKS = 32;
  localparam int unsigned SYNC_DEPTH = 2;
  // Framing lane value for slots 0..6, slot 0 in the most significant bit.
  localparam logic [SLOTS-1:0] FRAME_PATTERN = 7'b1100011;
endpackage

// File: rtl/pxl_reset_sync.sv
`timescale 1ns/1ps
module pxl_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/pxl_edge_capture.sv
`timescale 1ns/1ps
module pxl_edge_capture #(
  parameter int unsigned W      = 28,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         pix_clk_i,
  input  logic         strobe_rise_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] word_o,
  output logic         edge_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q, sync_d;
  logic [W-1:0]      pipe_q [STAGES];
  logic [W-1:0]      pipe_d [STAGES];
  logic              prev_q;
  logic [W-1:0]      word_q, word_d;
  logic              rise, fall, cap;

  // The data pipeline has the same depth as the clock synchronizer.
  always_comb begin
    sync_d[0] = pix_clk_i;
    pipe_d[0] = data_i;
    for (int i = 1; i < STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
      pipe_d[i] = pipe_q[i-1];
    end
  end

  always_comb begin
    rise   = sync_q[LAST] & ~prev_q;
    fall   = ~sync_q[LAST] & prev_q;
    cap    = strobe_rise_i ? rise : fall;
    word_d = cap ? pipe_q[LAST] : word_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      word_q <= '0;
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[LAST];
      word_q <= word_d;
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= pipe_d[i];
    end
  end

  assign word_o = word_q;
  assign edge_o = rise | fall;

  // R4: one pixel edge produces exactly one capture.
  assert_one_capture_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    cap |=> !(cap && $stable(strobe_rise_i)));
endmodule

// File: rtl/pxl_loss_detect.sv
`timescale 1ns/1ps
module pxl_loss_detect #(
  parameter int unsigned LIMIT = 32
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic edge_i,
  input  logic boundary_i,
  output logic lost_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lost_q, lost_d;

  always_comb begin
    cnt_d = cnt_q;
    if (edge_i)                         cnt_d = '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  // The flag is set at the limit and cleared at a boundary once an edge is back.
  always_comb begin
    lost_d = lost_q;
    if (cnt_q == CNT_MAX)          lost_d = 1'b1;
    else if (lost_q && boundary_i) lost_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

  assign lost_o = lost_q;

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  // R6: the mute is released only at a word boundary.
  assert_release_boundary_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (lost_q && !boundary_i) |=> lost_q);
endmodule

// File: rtl/pxl_lane_shifter.sv
`timescale 1ns/1ps
module pxl_lane_shifter #(
  parameter int unsigned LANES = 4,
  parameter int unsigned SLOTS = 7,
  parameter logic [SLOTS-1:0] PATTERN = 7'b1100011
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   mute_i,
  input  logic [LANES*SLOTS-1:0] word_i,
  output logic                   boundary_o,
  output logic [LANES-1:0]       data_o,
  output logic                   frame_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [LANES-1:0]  msb;
  logic              boundary;
  logic [LANES:0]    out_q, out_d;

  assign boundary = tick_i && (slot_q == LAST_SLOT);

  always_comb begin
    slot_d = slot_q;
    if (tick_i) slot_d = boundary ? '0 : slot_q + 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SLOTS-1:0] sh_q, sh_d;
    always_comb begin
      sh_d = sh_q;
      if (tick_i) sh_d = boundary ? word_i[g*SLOTS +: SLOTS] : {sh_q[SLOTS-2:0], 1'b0};
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= sh_d;
    end
    assign msb[g] = sh_q[SLOTS-1];
  end

  always_comb begin
    out_d = out_q;
    if (tick_i) out_d = mute_i ? '0 : {PATTERN[LAST_SLOT - slot_q], msb};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      out_q  <= '0;
    end else begin
      slot_q <= slot_d;
      out_q  <= out_d;
    end
  end

  assign boundary_o = boundary;
  assign data_o     = out_q[LANES-1:0];
  assign frame_o    = out_q[LANES];

  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    boundary |=> (slot_q == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick_i |=> $stable({frame_o, data_o}));
endmodule

// File: rtl/pxl_link_serializer.sv
`timescale 1ns/1ps
module pxl_link_serializer #(
  parameter int unsigned COLOR_W    = pxl_pkg::COLOR_W,
  parameter int unsigned SLOTS      = pxl_pkg::SLOTS,
  parameter int unsigned LOSS_TICKS = pxl_pkg::LOSS_TICKS,
  parameter int unsigned SYNC_DEPTH = pxl_pkg::SYNC_DEPTH,
  parameter logic [SLOTS-1:0] FRAME_PATTERN = pxl_pkg::FRAME_PATTERN,
  localparam int unsigned WORD_W = 3 * COLOR_W + 4,
  localparam int unsigned LANES  = WORD_W / SLOTS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pd_n,
  input  logic               bit_en,
  input  logic               pix_clk,
  input  logic               strobe_rise,
  input  logic [COLOR_W-1:0] red,
  input  logic [COLOR_W-1:0] green,
  input  logic [COLOR_W-1:0] blue,
  input  logic               line_sync,
  input  logic               frame_sync,
  input  logic               data_en,
  input  logic               spare,
  output logic [LANES-1:0]   lane_o,
  output logic               clk_lane_o
);
  logic              rst_int_n;
  logic [WORD_W-1:0] in_word, cap_word;
  logic              pix_edge, lost_w, boundary_w;
  logic [LANES-1:0]  data_w;
  logic              frame_w;

  assign in_word = {spare, data_en, frame_sync, line_sync, blue, green, red};

  pxl_reset_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_ni (rst_n & pd_n),
    .rst_no  (rst_int_n)
  );

  pxl_edge_capture #(.W(WORD_W), .STAGES(SYNC_DEPTH)) u_cap (
    .clk           (clk),
    .rst_ni        (rst_int_n),
    .pix_clk_i     (pix_clk),
    .strobe_rise_i (strobe_rise),
    .data_i        (in_word),
    .word_o        (cap_word),
    .edge_o        (pix_edge)
  );

  pxl_loss_detect #(.LIMIT(LOSS_TICKS)) u_loss (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .tick_i     (bit_en),
    .edge_i     (pix_edge),
    .boundary_i (boundary_w),
    .lost_o     (lost_w)
  );

  pxl_lane_shifter #(.LANES(LANES), .SLOTS(SLOTS), .PATTERN(FRAME_PATTERN)) u_shift (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .tick_i     (bit_en),
    .mute_i     (lost_w),
    .word_i     (cap_word),
    .boundary_o (boundary_w),
    .data_o     (data_w),
    .frame_o    (frame_w)
  );

  assign lane_o     = pd_n ? data_w  : {LANES{1'bz}};
  assign clk_lane_o = pd_n ? frame_w : 1'bz;

  // R5: a lost pixel clock silences all five lanes on the next tick.
  assert_mute_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bit_en && lost_w) |=> (data_w == '0 && frame_w == 1'b0));
endmodule

// File: tb/pxl_link_serializer_test.sv
`timescale 1ns/1ps
module pxl_link_serializer_test;
  localparam int N = 16;
  localparam logic [27:0] POISON = 28'h3C3C3C3;
  localparam logic [27:0] TBL [N] = '{
    28'h0000001, 28'h8000000, 28'hFFFFFFF, 28'h1234567,
    28'h7654321, 28'h0F0F0F0, 28'hF0F0F0F, 28'h4000000,
    28'h2000000, 28'h1000000, 28'h0FF0000, 28'h000FF00,
    28'h00000FF, 28'hAAAAAAA, 28'h5555555, 28'h0C30C30};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, pd_n, bit_en, pix_clk, strobe_rise;
  logic [27:0] stim;
  wire  [3:0]  lane;
  wire         clk_lane;

  pxl_link_serializer uut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .bit_en(bit_en),
    .pix_clk(pix_clk), .strobe_rise(strobe_rise),
    .red(stim[7:0]), .green(stim[15:8]), .blue(stim[23:16]),
    .line_sync(stim[24]), .frame_sync(stim[25]), .data_en(stim[26]), .spare(stim[27]),
    .lane_o(lane), .clk_lane_o(clk_lane));

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  // Monitor: finds words by the frame run, rebuilds them, checks their order.
  bit          mon_on = 0;
  bit          mon_started;
  int          mon_idx, mon_tick, mon_last, mon_gap_bad;
  logic [6:0]  fr_h;
  logic [6:0]  dh [4];
  logic [27:0] mon_got;

  task automatic mon_clear();
    mon_started = 0; mon_idx = 0; mon_tick = 0; mon_last = -1; mon_gap_bad = 0;
    fr_h = '0;
    for (int k = 0; k < 4; k++) dh[k] = '0;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      mon_tick++;
      fr_h = {fr_h[5:0], clk_lane};
      for (int k = 0; k < 4; k++) dh[k] = {dh[k][5:0], lane[k]};
      if (fr_h === 7'b1100011) begin
        if (mon_last >= 0 && (mon_tick - mon_last) != 7) mon_gap_bad++;
        mon_last = mon_tick;
        mon_got = {dh[3], dh[2], dh[1], dh[0]};
        if (!mon_started) begin
          for (int t = 0; t < N; t++)
            if (!mon_started && mon_got === TBL[t]) begin
              mon_started = 1;
              mon_idx = t + 1;
              check(1'b1, "R1", "anchor word", {4'h0, mon_got}, {4'h0, TBL[t]});
            end
        end else if (mon_idx < N) begin
          check(mon_got === TBL[mon_idx], "R1", "lane word", {4'h0, mon_got}, {4'h0, TBL[mon_idx]});
          mon_idx++;
        end
      end
    end
  end

  // Data is valid in phases 1..5; the chosen edge falls in phase 3 and the
  // other edge in phase 0, where the bus carries a poison value.
  task automatic run_pixels(int n, bit rise_mode);
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < 7; c++) begin
        @(posedge clk); #1;
        pix_clk = rise_mode ? (c >= 3) : (c < 3);
        stim    = (c >= 1 && c <= 5) ? ((i < N) ? TBL[i] : 28'h0) : POISON;
      end
    end
  endtask

  task automatic finish_run(string req);
    check(mon_idx == N, req, "words decoded in order", mon_idx, N);
    check(mon_gap_bad == 0, "R2", "seven ticks per word", mon_gap_bad, 0);
    check(mon_last >= 0, "R3", "frame run present", mon_last, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    summary();
  end

  initial begin
    bit seen, any;
    logic [4:0] snap;
    bit stable_ok;
    rst_n = 0; pd_n = 1; bit_en = 1; pix_clk = 0; strobe_rise = 0; stim = '0;
    mon_clear();
    repeat (3) @(negedge clk);
    check(lane === 4'h0 && clk_lane === 1'b0, "R8", "lanes low in reset", {clk_lane, lane}, 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // Falling-edge capture
    mon_clear(); mon_on = 1;
    run_pixels(N + 4, 1'b0);
    mon_on = 0;
    finish_run("R4");

    // Outputs hold while the enable is low
    @(posedge clk); #1 bit_en = 0;
    @(negedge clk); snap = {clk_lane, lane}; stable_ok = 1;
    repeat (10) begin
      @(negedge clk);
      if ({clk_lane, lane} !== snap) stable_ok = 0;
    end
    check(stable_ok, "R2", "hold with enable low", {clk_lane, lane}, snap);
    @(posedge clk); #1 bit_en = 1;

    // Pixel clock stopped: still running before the limit, silent after it
    repeat (12) @(negedge clk);
    seen = 0;
    repeat (7) begin @(negedge clk); seen |= (clk_lane === 1'b1); end
    check(seen, "R5", "frame lane active before limit", seen, 1);
    repeat (30) @(negedge clk);
    any = 0;
    repeat (14) begin @(negedge clk); any |= (clk_lane !== 1'b0) || (lane !== 4'h0); end
    check(!any, "R5", "lanes silenced after limit", {clk_lane, lane}, 0);

    // Edges return: output resumes without a reset
    mon_clear(); mon_on = 1;
    run_pixels(N + 4, 1'b0);
    mon_on = 0;
    finish_run("R6");

    // Rising-edge capture
    @(posedge clk); #1 rst_n = 0; strobe_rise = 1;
    repeat (2) @(posedge clk); #1 rst_n = 1;
    repeat (4) @(posedge clk);
    mon_clear(); mon_on = 1;
    run_pixels(N + 4, 1'b1);
    mon_on = 0;
    finish_run("R4");

    // Power-down floats the outputs; pixel clock already running at release
    @(posedge clk); #1 pd_n = 0;
    @(negedge clk);
    check(lane === 4'bzzzz && clk_lane === 1'bz, "R7", "outputs float", {clk_lane, lane}, 5'h1F);
    mon_clear(); mon_on = 1;
    fork
      run_pixels(N + 4, 1'b1);
      begin
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(lane === 4'bzzzz && clk_lane === 1'bz, "R7", "outputs float while held", {clk_lane, lane}, 5'h1F);
        #1 pd_n = 1;
      end
    join
    mon_on = 0;
    check(mon_idx == N, "R7", "words after release", mon_idx, N);

    summary();
  end
endmodule